// File: doc/BRIEF.md
# Integer ALU with Two-Stage Operation Decode

This block is the arithmetic and logic unit of a simple load/store processor core, together with the small decoder that picks its operation. The main instruction decoder supplies a 2-bit operation class, and the instruction supplies a 6-bit function field. From these two inputs the block forms an internal 3-bit control word, and that word selects one of five operations on the two operands: bitwise AND, bitwise OR, add, subtract, or signed set-less-than.

The whole block is combinational. A memory-access class always adds, to form an address. A branch class always subtracts, and the zero flag then reports equality. A register-register class decodes the function field. The top bit of the control word inverts operand B and injects a carry of one, so subtraction and set-less-than share the adder. Set-less-than takes its answer from the sign of the difference, corrected by the subtraction overflow, so the signed comparison is right even when A−B overflows.

Top module: `alu_unit`

## Requirements
- R1: With alu_op = 2'b00 the result is opa + opb modulo 2^32, whatever the function field holds.
- R2: With alu_op = 2'b01 the result is opa − opb modulo 2^32, whatever the function field holds.
- R3: With alu_op = 2'b10, function 6'b100000 gives opa + opb and function 6'b100010 gives opa − opb, both modulo 2^32.
- R4: With alu_op = 2'b10, function 6'b100100 gives opa & opb and function 6'b100101 gives opa | opb.
- R5: With alu_op = 2'b10 and function 6'b101010, the result is 1 when opa < opb as signed two's-complement numbers and 0 otherwise. Bits 31..1 of the result are always 0.
- R6: The set-less-than result of R5 is also correct for operand pairs where opa − opb overflows.
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: With alu_op = 2'b11, or with alu_op = 2'b10 and any function code not listed in R3 to R5, the result is opa + opb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the instruction |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Two things can happen in the same evaluation: a set-less-than whose subtraction overflows, and the zero flag that follows from a false comparison. The bench provokes this with pairs such as 0x7FFFFFFF against 0xFFFFFFFF. There the raw difference has its sign bit set and overflows, and the correct result is 0 with zero high. A design that uses only the sign bit would give 1 with zero low. The bench also drives branch-class subtractions of equal operands, and additions that wrap to zero, and checks that the flag comes from the final result whichever path produced it.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned OP_W    = 2;
    localparam int unsigned FUNCT_W = 6;
    localparam int unsigned CTRL_W  = 3;

    // Internal control word: bit 2 selects the inverted-B/carry-in path,
    // bits 1:0 select the output source.
    typedef enum logic [CTRL_W-1:0] {
        CTL_AND = 3'b000,
        CTL_OR  = 3'b001,
        CTL_ADD = 3'b010,
        CTL_SUB = 3'b110,
        CTL_SLT = 3'b111
    } alu_ctl_e;

    localparam logic [OP_W-1:0] CLS_MEM    = 2'b00;
    localparam logic [OP_W-1:0] CLS_BRANCH = 2'b01;
    localparam logic [OP_W-1:0] CLS_REG    = 2'b10;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0]    op_cls_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output alu_ctl_e           ctl_o
);

    alu_ctl_e ctl_d;

    always_comb begin
        ctl_d = CTL_ADD;
        unique case (op_cls_i)
            CLS_MEM:    ctl_d = CTL_ADD;
            CLS_BRANCH: ctl_d = CTL_SUB;
            CLS_REG: begin
                case (funct_i)
                    FN_ADD:  ctl_d = CTL_ADD;
                    FN_SUB:  ctl_d = CTL_SUB;
                    FN_AND:  ctl_d = CTL_AND;
                    FN_OR:   ctl_d = CTL_OR;
                    FN_SLT:  ctl_d = CTL_SLT;
                    default: ctl_d = CTL_ADD;
                endcase
            end
            default:    ctl_d = CTL_ADD;
        endcase
    end

    assign ctl_o = ctl_d;

    always_comb begin
        if (op_cls_i == CLS_MEM)
            assert_memclass_add_R1: assert (ctl_o == CTL_ADD);
        if (op_cls_i == CLS_BRANCH)
            assert_branchclass_sub_R2: assert (ctl_o == CTL_SUB);
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_ctl_e         ctl_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] b_eff;
        logic [WIDTH-1:0] sum;
        logic             ovf;
        logic             less;
        logic [WIDTH-1:0] res;
    } core_t;

    core_t core_d;
    logic  invert_b;

    assign invert_b = ctl_i[CTRL_W-1];

    always_comb begin
        core_d       = '0;
        core_d.b_eff = invert_b ? ~b_i : b_i;
        core_d.sum   = a_i + core_d.b_eff + {{(WIDTH-1){1'b0}}, invert_b};
        core_d.ovf   = (a_i[MSB] == core_d.b_eff[MSB]) && (core_d.sum[MSB] != a_i[MSB]);
        core_d.less  = core_d.sum[MSB] ^ core_d.ovf;
        unique case (ctl_i[1:0])
            2'b00:   core_d.res = a_i & b_i;
            2'b01:   core_d.res = a_i | b_i;
            2'b10:   core_d.res = core_d.sum;
            default: core_d.res = {{(WIDTH-1){1'b0}}, core_d.less};
        endcase
    end

    assign res_o = core_d.res;

    // Cross-checks between result and operands
    logic [WIDTH-1:0] undo_sub;
    logic [WIDTH-1:0] undo_add;
    assign undo_sub = res_o + b_i;
    assign undo_add = res_o - b_i;

    always_comb begin
        if (ctl_i == CTL_SUB)
            assert_sub_inverts_R2: assert (undo_sub == a_i);
        if (ctl_i == CTL_ADD)
            assert_add_inverts_R3: assert (undo_add == a_i);
        if (ctl_i == CTL_AND)
            assert_and_subset_R4: assert ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0);
        if (ctl_i == CTL_OR)
            assert_or_superset_R4: assert ((a_i & ~res_o) == '0 && (b_i & ~res_o) == '0);
        if (ctl_i == CTL_SLT)
            assert_slt_upper_clear_R5: assert (res_o[MSB:1] == '0);
    end

endmodule

// File: rtl/alu_zero_flag.sv
module alu_zero_flag #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    output logic             zero_o
);

    assign zero_o = (val_i == '0);

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [1:0]       alu_op,
    input  logic [5:0]       funct,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             zero
);

    alu_ctl_e ctl_q;

    alu_ctl_decode i_decode (
        .op_cls_i (alu_op),
        .funct_i  (funct),
        .ctl_o    (ctl_q)
    );

    alu_core #(.WIDTH(WIDTH)) i_core (
        .ctl_i (ctl_q),
        .a_i   (opa),
        .b_i   (opb),
        .res_o (result)
    );

    alu_zero_flag #(.WIDTH(WIDTH)) i_zero (
        .val_i  (result),
        .zero_o (zero)
    );

    always_comb begin
        if (zero)
            assert_zero_means_clear_R7: assert (result == '0);
        if (alu_op == CLS_BRANCH && opa == opb)
            assert_branch_equal_zero_R7: assert (zero);
    end

endmodule

// File: tb/test_alu_unit.sv
module test_alu_unit;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        z;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 6'h00, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0, 4'd1}, // R1
        '{2'b00, 6'h2A, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 4'd1}, // R1 wraps, R7
        '{2'b01, 6'h24, 32'h00000009, 32'h00000009, 32'h00000000, 1'b1, 4'd2}, // R2
        '{2'b01, 6'h00, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0, 4'd2}, // R2
        '{2'b10, 6'h20, 32'h12345678, 32'h11111111, 32'h23456789, 1'b0, 4'd3}, // R3
        '{2'b10, 6'h22, 32'h00000100, 32'h00000001, 32'h000000FF, 1'b0, 4'd3}, // R3
        '{2'b10, 6'h24, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 4'd4}, // R4
        '{2'b10, 6'h25, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 1'b0, 4'd4}, // R4
        '{2'b10, 6'h24, 32'hAAAAAAAA, 32'h55555555, 32'h00000000, 1'b1, 4'd4}, // R4
        '{2'b10, 6'h2A, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 4'd5}, // R5
        '{2'b10, 6'h2A, 32'h00000005, 32'h00000003, 32'h00000000, 1'b1, 4'd5}, // R5
        '{2'b10, 6'h2A, 32'h00000007, 32'h00000007, 32'h00000000, 1'b1, 4'd5}, // R5
        '{2'b10, 6'h2A, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 4'd6}, // R6
        '{2'b10, 6'h2A, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd6}, // R6
        '{2'b10, 6'h2A, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 4'd6}, // R6
        '{2'b10, 6'h3F, 32'h00000002, 32'h00000003, 32'h00000005, 1'b0, 4'd8}, // R8
        '{2'b11, 6'h22, 32'h00000010, 32'h00000001, 32'h00000011, 1'b0, 4'd8}, // R8
        '{2'b10, 6'h00, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b1, 4'd8}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alu_op = '0;
    logic [5:0]  funct = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_unit i_alu_unit (
        .alu_op (alu_op),
        .funct  (funct),
        .opa    (opa),
        .opb    (opb),
        .result (result),
        .zero   (zero)
    );

    task automatic apply_check(input logic [1:0] op, input logic [5:0] fn,
                               input logic [31:0] a, input logic [31:0] b,
                               input logic [31:0] exp_res, input logic exp_z,
                               input string tag);
        @(posedge clk);
        alu_op = op; funct = fn; opa = a; opb = b;
        @(negedge clk);
        checks++;
        if (result !== exp_res || zero !== exp_z) begin
            errors++;
            $display("FAIL %s: op=%b fn=%h a=%h b=%h result=%h zero=%b expected result=%h zero=%b",
                     tag, op, fn, a, b, result, zero, exp_res, exp_z);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero inputs add to zero, flag high (R1, R7)
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || zero !== 1'b1) begin
            errors++;
            $display("FAIL R1/R7 reset: result=%h zero=%b expected result=00000000 zero=1",
                     result, zero);
        end

        for (int i = 0; i < NV; i++)
            apply_check(VECS[i].op, VECS[i].fn, VECS[i].a, VECS[i].b,
                        VECS[i].res, VECS[i].z, $sformatf("R%0d vec%0d", VECS[i].req, i));

        // R7: a single set bit anywhere keeps zero low
        for (int i = 0; i < 32; i++)
            apply_check(2'b10, 6'h25, 32'h0, 32'h1 << i, 32'h1 << i, 1'b0, "R7 single bit");

        // R5: every SLT result has bits 31..1 clear, sign boundaries
        apply_check(2'b10, 6'h2A, 32'h80000000, 32'h80000000, 32'h0, 1'b1, "R5 min equal");
        apply_check(2'b10, 6'h2A, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h1, 1'b0, "R5 negatives");
        // R6: max positive vs min negative, difference overflows
        apply_check(2'b10, 6'h2A, 32'h7FFFFFFF, 32'h80000000, 32'h0, 1'b1, "R6 max vs min");
        // R2: branch class with overflowing difference
        apply_check(2'b01, 6'h2A, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, "R2 ovf");
        // R8: ALUOp 11 ignores an AND function code
        apply_check(2'b11, 6'h24, 32'h0000000F, 32'h000000F0, 32'h000000FF, 1'b0, "R8 op11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule